// File: doc/BRIEF.md
# Clock Control Register with ADC Clock-Enable Divider

This block holds one 16-bit clock configuration register on a simple register bus. The register carries two 2-bit crystal load-capacitance selects, three oscillator source enables and a 3-bit ADC clock divide code. The bus has an address, a write strobe, write data and combinational read data. Reserved bit positions are never stored, so they always read as zero. The register returns to its default only on power-on reset. The separate general reset clears the divider and leaves the register alone.

The divider produces `adc_clk_en` from the system clock. This is a one-cycle enable pulse that fires once every N system clocks, where N is a power of two picked by the divide code. An ADC clocks its front-end selection, track-and-hold and conversion steps on this pulse. While `stop_mode` is high no pulse is produced and the count is held at zero.

Top module: `ckc_top`

## Requirements
- R1: While `por_n` is low the register loads 0x0002. After power-on reset only `rc_osc_en` is 1 and all other fields are 0.
- R2: Holding `rst_n` low resets the divider only. The register value and its field outputs stay unchanged.
- R3: Bits 15:12, 4 and 3 always read 0, and writing them has no effect. Only mask 0x0FE7 is stored.
- R4: A write takes effect on the clock edge at which `bus_wr` is high and `bus_addr` equals `REG_ADDR`. The field outputs then show the new value. The bit positions are: 11:10 = `xtal_out_cap`, 9:8 = `xtal_in_cap`, 2 = `ext_clk_en`, 1 = `rc_osc_en`, 0 = `xtal_osc_en`.
- R5: In the same cycle, `bus_rdata` returns the stored value when `bus_addr` equals `REG_ADDR`, and 0 for any other address.
- R6: The divide code sits in bits 7:5. Code 0 selects divide by 1, code 1 by 2, code 2 by 4, code 3 by 8 and code 4 by 16.
- R7: Codes 5, 6 and 7 all divide by 16.
- R8: At divide by 1, outside stop mode and outside a restart cycle, `adc_clk_en` is high every cycle.
- R9: At divide by N (N > 1), `adc_clk_en` is high for exactly one cycle in every N.
- R10: A write that changes the divide code restarts the count. `adc_clk_en` is low in the cycle after the write edge. The first pulse comes in the cycle after the N-th edge, counting the write edge as edge 0.
- R11: While `stop_mode` is high, `adc_clk_en` is low.
- R12: After `stop_mode` falls, the count resumes from zero. The first pulse is in cycle N-1, where the cycle in which `stop_mode` first reads low is cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | General reset, active low, synchronous, divider only |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| stop_mode | input | 1 | Stop mode; suppresses the ADC enable |
| adc_clk_en | output | 1 | ADC clock-enable pulse |
| xtal_out_cap | output | 2 | Crystal output load-capacitance select |
| xtal_in_cap | output | 2 | Crystal input load-capacitance select |
| ext_clk_en | output | 1 | External clock input enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |

## Verification
Read data and the stop gating are combinational, so the bench checks them a few time units after it changes the inputs, in the same cycle. Field outputs and read-back change on the edge that accepts a write and are sampled at the following falling edge. For each code, the bench counts falling edges after the write edge and expects the first pulse at edge N, then counts exactly 64/N pulses over the next 64 cycles. For stop release it counts from the first low-stop cycle and expects the first pulse at N-1. All sampling happens at falling edges, and the bench drives its inputs at those same points.

// File: rtl/ckc_pkg.sv
// Package: shared constants for the clock control register.
// Assumes a 16-bit register whose field positions are fixed by software.
package ckc_pkg;
    localparam int DATA_W      = 16;
    localparam int CODE_W      = 3;
    localparam int CODE_LSB    = 5;
    localparam int OCAP_LSB    = 10;
    localparam int ICAP_LSB    = 8;
    localparam int EXT_BIT     = 2;
    localparam int RC_BIT      = 1;
    localparam int XTAL_BIT    = 0;
    localparam logic [DATA_W-1:0] WR_MASK   = 16'h0FE7;
    localparam logic [DATA_W-1:0] RESET_VAL = 16'h0002;
endpackage

// File: rtl/ckc_regfile.sv
// Module: single configuration register with masked storage and read-back.
// Assumes: por_n is the only reset that touches the register; reserved bits
// are never stored, so read data needs no extra masking.
module ckc_regfile
    import ckc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] reg_q
);
    logic hit;

    // Address decode shared by read and write.
    assign hit = (bus_addr == REG_ADDR);

    // Register storage: power-on default, masked write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            reg_q <= RESET_VAL;
        end else if (bus_wr && hit) begin
            reg_q <= bus_wdata & WR_MASK;
        end
    end

    // Combinational read mux: value on hit, zero elsewhere.
    always_comb begin
        bus_rdata = hit ? reg_q : '0;
    end
endmodule

// File: rtl/ckc_div_decode.sv
// Module: turns the divide code into a terminal count (N-1) for the counter.
// Assumes: codes above MAX_LOG2 saturate to the largest ratio.
module ckc_div_decode #(
    parameter int CODE_W   = 3,
    parameter int MAX_LOG2 = 4,
    localparam int CNT_W   = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ratio_m1
);
    int unsigned sel_log2;

    // Saturate the code to the supported exponent range.
    always_comb begin
        sel_log2 = (int'(code) > MAX_LOG2) ? MAX_LOG2 : int'(code);
    end

    // Terminal count is a run of ones of length sel_log2.
    generate
        for (genvar b = 0; b < CNT_W; b++) begin : g_tc
            assign ratio_m1[b] = (b < sel_log2);
        end
    endgenerate
endmodule

// File: rtl/ckc_divider.sv
// Module: counter producing a one-cycle enable every (ratio_m1+1) clocks.
// Assumes: stop_mode may change at any cycle; a code change restarts the count.
module ckc_divider #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_mode,
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  ratio_m1,
    output logic              adc_clk_en
);
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] code_q;
    logic              restart;

    // A code differing from the one last seen marks a restart cycle.
    assign restart = (code != code_q);

    // Count up to the terminal count; clear on reset, stop or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            code_q <= '0;
        end else if (stop_mode || restart) begin
            cnt    <= '0;
            code_q <= code;
        end else if (cnt == ratio_m1) begin
            cnt    <= '0;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // Enable pulse at terminal count, gated by stop and restart.
    always_comb begin
        adc_clk_en = !stop_mode && !restart && (cnt == ratio_m1);
    end
endmodule

// File: rtl/ckc_top.sv
// Module: clock control register plus ADC clock-enable divider.
// Assumes: both resets are synchronous and active low; por_n also clears the
// divider so it starts in step with the register default.
module ckc_top
    import ckc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C,
    parameter int MAX_LOG2 = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              stop_mode,
    output logic              adc_clk_en,
    output logic [1:0]        xtal_out_cap,
    output logic [1:0]        xtal_in_cap,
    output logic              ext_clk_en,
    output logic              rc_osc_en,
    output logic              xtal_osc_en
);
    localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

    logic [DATA_W-1:0] reg_q;
    logic [CODE_W-1:0] div_code;
    logic [CNT_W-1:0]  ratio_m1;
    logic              div_rst_n;

    // Divider reset merges both reset sources.
    assign div_rst_n = por_n & rst_n;

    ckc_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reg_q     (reg_q)
    );

    // Field extraction from the stored register.
    assign div_code     = reg_q[CODE_LSB +: CODE_W];
    assign xtal_out_cap = reg_q[OCAP_LSB +: 2];
    assign xtal_in_cap  = reg_q[ICAP_LSB +: 2];
    assign ext_clk_en   = reg_q[EXT_BIT];
    assign rc_osc_en    = reg_q[RC_BIT];
    assign xtal_osc_en  = reg_q[XTAL_BIT];

    ckc_div_decode #(.CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2)) u_dec (
        .code     (div_code),
        .ratio_m1 (ratio_m1)
    );

    ckc_divider #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_div (
        .clk        (clk),
        .rst_n      (div_rst_n),
        .stop_mode  (stop_mode),
        .code       (div_code),
        .ratio_m1   (ratio_m1),
        .adc_clk_en (adc_clk_en)
    );
endmodule

// File: rtl/ckc_checker.sv
// Module: property checker for ckc_top, attached by bind.
// Assumes: observes only top ports and the decoded divide code.
module ckc_checker
    import ckc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              stop_mode,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [2:0]        div_code,
    input logic              adc_clk_en,
    input logic [6:0]        field_q
);
    // R11: no enable while stopped.
    p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!por_n)
        stop_mode |-> !adc_clk_en);

    // R3: reserved bits read zero.
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rdata & ~WR_MASK) == 16'h0000);

    // R5: unmatched addresses read zero.
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 16'h0000));

    // R4: accepted write appears on the field outputs next cycle.
    p_wr_takes_r4: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr == REG_ADDR) |=>
        (field_q == {$past(bus_wdata[11:8]), $past(bus_wdata[2:0])}));

    // R2: without a write the fields hold, whatever rst_n does.
    p_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_wr && bus_addr == REG_ADDR) |=> $stable(field_q));

    // R9: a pulse at ratio above one lasts a single cycle.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (adc_clk_en && div_code != 3'd0) |=> !adc_clk_en);

    // R8: settled divide-by-1 gives a continuous enable.
    p_div1_high_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (div_code == 3'd0 && $past(div_code) == 3'd0 && !stop_mode) |-> adc_clk_en);
endmodule

bind ckc_top ckc_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .stop_mode  (stop_mode),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .div_code   (div_code),
    .adc_clk_en (adc_clk_en),
    .field_q    ({xtal_out_cap, xtal_in_cap, ext_clk_en, rc_osc_en, xtal_osc_en})
);

// File: tb/tb_ckc_top.sv
// Bench: vector table of writes with expected read-back and divide ratio,
// then directed tests for resets and stop mode.
module tb_ckc_top;
    localparam logic [7:0] RA = 8'h0C;

    typedef struct packed {
        logic [15:0] wdata;
        logic [15:0] rexp;
        logic [4:0]  ratio;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'hFA7D, 16'h0A65, 5'd8},
        '{16'h0502, 16'h0502, 5'd1},
        '{16'h0323, 16'h0323, 5'd2},
        '{16'h8C5C, 16'h0C44, 5'd4},
        '{16'h0081, 16'h0081, 5'd16},
        '{16'h00A6, 16'h00A6, 5'd16},
        '{16'h0FC7, 16'h0FC7, 5'd16},
        '{16'hFFFF, 16'h0FE7, 5'd16},
        '{16'h0060, 16'h0060, 5'd8}
    };

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = RA;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        stop_mode = 1'b0;
    logic        adc_clk_en;
    logic [1:0]  xtal_out_cap, xtal_in_cap;
    logic        ext_clk_en, rc_osc_en, xtal_osc_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    ckc_top #(.ADDR_W(8), .REG_ADDR(RA)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_mode(stop_mode), .adc_clk_en(adc_clk_en),
        .xtal_out_cap(xtal_out_cap), .xtal_in_cap(xtal_in_cap),
        .ext_clk_en(ext_clk_en), .rc_osc_en(rc_osc_en), .xtal_osc_en(xtal_osc_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        bus_addr = RA; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_fields(input logic [15:0] e, input string req);
        check({xtal_out_cap, xtal_in_cap, ext_clk_en, rc_osc_en, xtal_osc_en}
              == {e[11:8], e[2:0]}, req,
              {xtal_out_cap, xtal_in_cap, ext_clk_en, rc_osc_en, xtal_osc_en},
              {e[11:8], e[2:0]});
    endtask

    task automatic read_check(input logic [15:0] e, input string req);
        bus_addr = RA; #1;
        check(bus_rdata == e, req, bus_rdata, e);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog all reqs: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int first;
        int pulses;
        repeat (3) @(negedge clk);
        // R1: power-on default.
        read_check(16'h0002, "R1 reset read");
        check_fields(16'h0002, "R1 reset fields");
        por_n = 1'b1; rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            do_write(VECS[v].wdata);
            // R10: restart cycle has no pulse.
            check(adc_clk_en == 1'b0, "R10 restart cycle low", adc_clk_en, 0);
            read_check(VECS[v].rexp, "R3/R5 read-back");
            check_fields(VECS[v].rexp, "R4 fields");
            bus_addr = 8'h0D; #1;
            check(bus_rdata == 16'h0, "R5 other address", bus_rdata, 0);
            bus_addr = RA;
            first = 0;
            for (int i = 1; i <= 40 && first == 0; i++) begin
                @(negedge clk);
                if (adc_clk_en) first = i;
            end
            // R6 R7 R10: first pulse after N edges.
            check(first == int'(VECS[v].ratio), "R6/R7/R10 first pulse", first, VECS[v].ratio);
            pulses = 0;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (adc_clk_en) pulses++;
            end
            // R8 R9: pulse count over 64 cycles.
            check(pulses == 64 / int'(VECS[v].ratio), "R8/R9 pulse count", pulses,
                  64 / int'(VECS[v].ratio));
        end

        // R2: general reset leaves the register alone.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        read_check(16'h0060, "R2 during rst_n");
        rst_n = 1'b1;
        @(negedge clk);
        read_check(16'h0060, "R2 after rst_n");
        check_fields(16'h0060, "R2 fields");

        // R11: stop mode at divide by 1.
        do_write(16'h0000);
        repeat (3) @(negedge clk);
        check(adc_clk_en == 1'b1, "R8 running before stop", adc_clk_en, 1);
        stop_mode = 1'b1; #1;
        check(adc_clk_en == 1'b0, "R11 stop immediate", adc_clk_en, 0);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (adc_clk_en) pulses++;
        end
        check(pulses == 0, "R11 stop quiet", pulses, 0);

        // R12: resume from zero at divide by 4.
        do_write(16'h0040);
        repeat (3) @(negedge clk);
        check(adc_clk_en == 1'b0, "R11 stop after write", adc_clk_en, 0);
        stop_mode = 1'b0; #1;
        first = adc_clk_en ? 100 : 0;
        for (int i = 1; i <= 20 && first == 0; i++) begin
            @(negedge clk);
            if (adc_clk_en) first = i;
        end
        check(first == 3, "R12 first pulse after stop", first, 3);

        // R1: power-on reset in mid run.
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        read_check(16'h0002, "R1 por mid run");
        check_fields(16'h0002, "R1 por fields");
        @(negedge clk);
        check(adc_clk_en == 1'b1, "R8 divide by 1 after por", adc_clk_en, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule